// File: doc/BRIEF.md
# Byte-Bit Read-Modify-Write Sequencer

This block carries out a single-bit operation on one byte held in memory. A command supplies a base address, a signed 16-bit offset, a 3-bit bit index and one of four operations: force the bit to one, flip it, force it to zero, or only inspect it. The sequencer adds the sign-extended offset to the base and fetches the byte over a byte-wide synchronous memory port. It modifies the chosen bit and stores the byte back. An inspect command skips the store.

Every command, inspect included, sets the zero output from the chosen bit as it was before any change. The zero output is high when that bit was 0. It is the only status the block produces, and it holds its value between commands. The block accepts a command only while idle. Each command finishes with a one-cycle completion pulse, and the zero output takes its new value in that same cycle.

Top module: `bitrmw_unit`

## Requirements
- R1: The 2-bit operation code selects the action: 0 sets the bit, 1 inverts it, 2 clears it, 3 only tests it.
- R2: The 3-bit index n selects the bit of weight 2^n, for n from 0 (least significant) to 7.
- R3: The memory address is the base plus the 16-bit offset sign-extended to 32 bits, modulo 2^32. It is presented unchanged on the address output for the whole read and the whole write.
- R4: At completion the zero output is 1 if the selected bit of the fetched byte was 0, and 0 if it was 1. This holds for every operation.
- R5: The zero output is 0 after reset. It changes only in a cycle in which the completion pulse is high.
- R6: The stored byte is the fetched byte with only the selected bit changed: OR with the mask for set, XOR for invert, AND with the inverted mask for clear.
- R7: A test command makes exactly one read and never raises the write request.
- R8: The read request stays high until a cycle with the ready input high. So does the write request. Each command makes exactly one read handshake, and set, invert and clear each make exactly one write handshake.
- R9: The completion output is a single-cycle pulse. It follows the write handshake, or the read handshake for a test.
- R10: A start signal is ignored unless the sequencer is idle, including a start held during the completion cycle.
- R11: During and right after reset there are no memory requests, no completion pulse and the zero output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Command valid; taken only when idle |
| cmd_op | input | 2 | Operation code (R1) |
| cmd_base | input | 32 | Base address |
| cmd_disp | input | 16 | Signed address offset |
| cmd_bit | input | 3 | Bit index within the byte |
| mem_rd_req | output | 1 | Read request |
| mem_wr_req | output | 1 | Write request |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Fetched byte, valid with ready during a read |
| mem_ready | input | 1 | Memory handshake acknowledge |
| done | output | 1 | Completion pulse |
| zflag | output | 1 | Zero flag from the original bit value |

## Verification
Two things can fall in the same cycle here. A completion pulse, which also moves the zero output, can coincide with a fresh start request. A start can also arrive while a read or write handshake is still pending. The bench holds a second command's start high through a whole sequence, including the completion cycle. It then judges at the memory port that only one read and at most one write occurred, all at the first command's address, and that no further request follows. The main sweep covers every operation, bit index and several byte patterns with 0 to 2 memory wait cycles. Each result is compared against values the bench computes itself.

// File: rtl/bitrmw_pkg.sv
package bitrmw_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        BOP_SET = 2'd0,
        BOP_INV = 2'd1,
        BOP_CLR = 2'd2,
        BOP_TST = 2'd3
    } bit_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        bit_op_e          op;
        logic [IDX_W-1:0] idx;
    } bit_cmd_t;

    function automatic logic [BYTE_W-1:0] bit_mask(input logic [IDX_W-1:0] idx);
        return BYTE_W'(1) << idx;
    endfunction

endpackage

// File: rtl/bitrmw_ea.sv
module bitrmw_ea #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] eff
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign eff      = base + disp_ext;
endmodule

// File: rtl/bitrmw_modify.sv
module bitrmw_modify
    import bitrmw_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    input  bit_cmd_t          cmd,
    output logic [BYTE_W-1:0] dout,
    output logic              zero
);
    logic [BYTE_W-1:0] mask;

    assign mask = bit_mask(cmd.idx);
    assign zero = ~din[cmd.idx];

    always_comb begin
        unique case (cmd.op)
            BOP_SET: dout = din | mask;
            BOP_INV: dout = din ^ mask;
            BOP_CLR: dout = din & ~mask;
            default: dout = din;
        endcase
    end

    // R6
    always_comb begin
        other_bits_chk: assert (((dout ^ din) & ~mask) == '0);
    end
endmodule

// File: rtl/bitrmw_ctrl.sv
module bitrmw_ctrl
    import bitrmw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_test,
    input  logic mem_ready,
    output logic accept,
    output logic rd_req,
    output logic wr_req,
    output logic in_modify,
    output logic finish,
    output logic done
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)     state_d = ST_READ;
            ST_READ:   if (mem_ready) state_d = ST_MODIFY;
            ST_MODIFY: state_d = is_test ? ST_DONE : ST_WRITE;
            ST_WRITE:  if (mem_ready) state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign accept    = (state_q == ST_IDLE) && start;
    assign rd_req    = (state_q == ST_READ);
    assign wr_req    = (state_q == ST_WRITE);
    assign in_modify = (state_q == ST_MODIFY);
    assign finish    = (state_d == ST_DONE) && (state_q != ST_DONE);
    assign done      = (state_q == ST_DONE);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !mem_ready) |=> rd_req);

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !mem_ready) |=> wr_req);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_READ) |=> (state_q != ST_READ));
endmodule

// File: rtl/bitrmw_unit.sv
module bitrmw_unit
    import bitrmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_start,
    input  logic [1:0]           cmd_op,
    input  logic [ADDR_W-1:0]    cmd_base,
    input  logic [DISP_W-1:0]    cmd_disp,
    input  logic [IDX_W-1:0]     cmd_bit,
    output logic                 mem_rd_req,
    output logic                 mem_wr_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BYTE_W-1:0]    mem_wdata,
    input  logic [BYTE_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic                 done,
    output logic                 zflag
);
    bit_cmd_t          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] eff;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] mod_out;
    logic              mod_zero;
    logic              zflag_q;
    logic              accept, in_modify, finish;

    bitrmw_ea #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ea (
        .base (cmd_base),
        .disp (cmd_disp),
        .eff  (eff)
    );

    bitrmw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_start),
        .is_test   (cmd_q.op == BOP_TST),
        .mem_ready (mem_ready),
        .accept    (accept),
        .rd_req    (mem_rd_req),
        .wr_req    (mem_wr_req),
        .in_modify (in_modify),
        .finish    (finish),
        .done      (done)
    );

    bitrmw_modify u_mod (
        .din  (data_q),
        .cmd  (cmd_q),
        .dout (mod_out),
        .zero (mod_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '{op: BOP_TST, idx: '0};
            addr_q  <= '0;
            data_q  <= '0;
            zflag_q <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q  <= '{op: bit_op_e'(cmd_op), idx: cmd_bit};
                addr_q <= eff;
            end
            if (mem_rd_req && mem_ready) data_q <= mem_rdata;
            if (finish) zflag_q <= mod_zero;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = mod_out;
    assign zflag     = zflag_q;

    // R5
    zflag_only_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(zflag) |-> done);

    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd_req || mem_wr_req) && !accept) |=> (!(mem_rd_req || mem_wr_req) || $stable(mem_addr)));

    // R7
    test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (in_modify && cmd_q.op == BOP_TST) |=> !mem_wr_req);

    // R11
    always_comb begin
        if (!rst) no_dual_req_chk: assert (!(mem_rd_req && mem_wr_req));
    end
endmodule

// File: tb/bitrmw_unit_bench.sv
module bitrmw_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_disp = '0;
    logic [2:0]  cmd_bit = '0;
    logic        mem_rd_req, mem_wr_req;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        done, zflag;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    int wcnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] rd_addr_seen, wr_addr_seen;
    logic        prev_z = 1'b0;
    logic [7:0]  mem [256];

    always #4 clk = ~clk;

    bitrmw_unit u_bitrmw_unit (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_base(cmd_base), .cmd_disp(cmd_disp), .cmd_bit(cmd_bit),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done), .zflag(zflag)
    );

    // memory responder: decides ready at negedge; handshake completes at next posedge
    always @(negedge clk) begin
        if (mem_rd_req || mem_wr_req) begin
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                wcnt = 0;
                if (mem_rd_req) begin
                    mem_rdata = mem[mem_addr[7:0]];
                    rd_cnt++;
                    rd_addr_seen = mem_addr;
                end else begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_cnt++;
                    wr_addr_seen = mem_addr;
                end
            end else begin
                mem_ready = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // run one command; if hold_start, start stays high through the completion cycle (R10)
    task automatic run_op(input logic [1:0] op, input logic [2:0] bi, input logic [31:0] base,
                          input logic [15:0] disp, input logic [7:0] init, input bit hold_start);
        logic [31:0] ea;
        logic [7:0]  m, exp_b;
        logic        exp_z;
        int          cyc;
        bit          seen;
        ea = base + {{16{disp[15]}}, disp};
        m  = 8'd1 << bi;                       // R2
        case (op)                              // R1
            2'd0: exp_b = init | m;
            2'd1: exp_b = init ^ m;
            2'd2: exp_b = init & ~m;
            default: exp_b = init;
        endcase
        exp_z = ~init[bi];
        @(negedge clk);
        mem[ea[7:0]] = init;
        rd_cnt = 0; wr_cnt = 0;
        cmd_start = 1'b1; cmd_op = op; cmd_bit = bi; cmd_base = base; cmd_disp = disp;
        @(negedge clk);
        if (hold_start) begin
            cmd_op = ~op; cmd_base = base + 32'h40; cmd_bit = ~bi;
        end else cmd_start = 1'b0;
        seen = 0;
        for (int c = 0; c < 40 && !seen; c++) begin
            if (done) seen = 1;
            else begin
                // R5 zero output holds until completion
                if (zflag !== prev_z) check("R5 hold", {31'd0, zflag}, {31'd0, prev_z});
                @(negedge clk);
            end
            cyc = c;
        end
        check("R9 done seen", {31'd0, seen}, 32'd1);
        check("R4 zflag", {31'd0, zflag}, {31'd0, exp_z});
        check("R6 byte", {24'd0, mem[ea[7:0]]}, {24'd0, exp_b});
        check("R3 read addr", rd_addr_seen, ea);
        check("R8 one read", rd_cnt, 1);
        if (op == 2'd3) check("R7 no write", wr_cnt, 0);
        else begin
            check("R8 one write", wr_cnt, 1);
            check("R3 write addr", wr_addr_seen, ea);
        end
        prev_z = exp_z;
        @(negedge clk);
        cmd_start = 1'b0;
        check("R9 single pulse", {31'd0, done}, 32'd0);
        if (hold_start) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check("R10 no extra request", {30'd0, mem_rd_req, mem_wr_req}, 32'd0);
            end
            check("R10 counts", rd_cnt + wr_cnt, (op == 2'd3) ? 1 : 2);
        end
        if (cyc < 0) $display("unreachable");
    endtask

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rd_req", {31'd0, mem_rd_req}, 32'd0);
        check("R11 wr_req", {31'd0, mem_wr_req}, 32'd0);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 zflag", {31'd0, zflag}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 idle after reset", {30'd0, mem_rd_req, done}, 32'd0);
        // sweep every op, bit index and pattern with varying latency
        for (int op = 0; op < 4; op++)
            for (int bi = 0; bi < 8; bi++)
                for (int p = 0; p < 4; p++) begin
                    lat = (op + bi + p) % 3;
                    run_op(2'(op), 3'(bi), 32'h1000_0000 + 32'(p * 3),
                           bi[0] ? 16'hFF80 - 16'(p) : 16'h0123 + 16'(p * 7),
                           pats[p], 1'b0);
                end
        // R3 address wrap with most negative offset
        lat = 1;
        run_op(2'd0, 3'd7, 32'h0000_0010, 16'h8000, 8'h00, 1'b0);
        run_op(2'd2, 3'd0, 32'hFFFF_FFF0, 16'h0020, 8'h01, 1'b0);
        // R10 start held during busy and completion cycles
        lat = 2;
        run_op(2'd1, 3'd3, 32'h0000_2000, 16'h0005, 8'h08, 1'b1);
        lat = 0;
        run_op(2'd3, 3'd6, 32'h0000_3000, 16'hFFFE, 8'h00, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule